// File: doc/BRIEF.md
# Interleaved Thread-Group Issue Scheduler

This block sits in front of one shared SIMD datapath and holds a set of resident thread groups, each owning a context slot. On every cycle it picks one runnable group and presents its ID to the datapath's single fetch/decode front end. When the datapath reports that the issued group has started a long-latency access, such as a texture fetch taking hundreds to thousands of cycles, the group is parked. The scheduler then turns to the other resident groups, so the wait is hidden behind useful work. When the matching completion returns, the group becomes eligible again.

A fixed pool of context storage can be carved into few large contexts or many small ones. The `cfg_slots` input states how many slots the current carving provides, and is sampled when a `launch` pulse starts a new batch of groups. More slots give more latency hiding. Each slot walks through the states SLOT_START, SLOT_READY, SLOT_STALL and SLOT_DONE. The transitions are: launch (any state to SLOT_START when enabled, else SLOT_DONE); issue (SLOT_START or SLOT_READY to SLOT_READY); stall (issue with `stall_req` to SLOT_STALL, storing the tag); wake (SLOT_STALL to SLOT_READY on a completion with matching ID and tag); retire (issue with `retire_req` to SLOT_DONE). Reset puts every slot in SLOT_DONE.

Top module: `grp_sched`

## Requirements
- R1: After reset no group is issued (`issue_valid` low) until the first `launch` pulse.
- R2: A `launch` with `cfg_slots` = K enables slots 0 to min(K, NUM_SLOTS)-1; other slots are never issued. `cfg_slots` = 0 enables none.
- R3: Selection is round-robin over runnable slots (SLOT_START or SLOT_READY), searching upward from the slot after the last issued one and wrapping. After reset or launch the search starts at slot 0. A launch takes effect at the next edge, so slot 0 is issued in the cycle after the pulse.
- R4: A group issued in a cycle with `stall_req` high enters SLOT_STALL and is not issued again until it is woken.
- R5: A completion (`cpl_valid`, `cpl_gid`, `cpl_tag`) for a stalled group whose tag equals the tag stored at stall time makes that group runnable from the next cycle.
- R6: A completion whose tag differs from the stored one, or whose group is not stalled, has no effect.
- R7: `issue_valid` is low in any cycle in which no slot is runnable.
- R8: A group issued with `retire_req` high enters SLOT_DONE and is not issued again before the next launch.
- R9: When `retire_req` and `stall_req` are both high for an issue, retire wins and no completion revives the group.
- R10: A `launch` overrides all other inputs in its cycle and restarts every enabled slot in SLOT_START, discarding stalls and retirements.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_slots | input | CNT_W | Number of context slots to enable, sampled at launch |
| launch | input | 1 | Start a new batch of groups in the enabled slots |
| stall_req | input | 1 | The group issued this cycle begins a long-latency operation |
| stall_tag | input | TAG_W | Latency tag stored with the stall |
| retire_req | input | 1 | The group issued this cycle has finished |
| cpl_valid | input | 1 | A long-latency operation has completed |
| cpl_gid | input | GID_W | Group the completion belongs to |
| cpl_tag | input | TAG_W | Tag of the completed operation |
| issue_valid | output | 1 | A group is issued this cycle |
| issue_gid | output | GID_W | ID of the issued group |

## Verification
A slot stuck in the wrong state shows at the ports within one round-robin sweep. A lost wake leaves a group missing from the issue order once its completion has returned. A spurious wake puts a stalled group back into the order before its completion, and a missed stall lets it be issued in the very next turn. A damaged rotation pointer appears in the first cycle after the damage as a wrong `issue_gid`. A bad enable mask appears as an ID at or above the configured slot count. Per-group latency counters drive the completions, so every resume is tied to a known return time and the issue order is compared on every cycle.

// File: rtl/grp_sched_pkg.sv
package grp_sched_pkg;

    typedef enum logic [1:0] {
        SLOT_START,
        SLOT_READY,
        SLOT_STALL,
        SLOT_DONE
    } slot_state_e;

endpackage

// File: rtl/grp_slot.sv
module grp_slot
    import grp_sched_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enabled,
    input  logic             launch,
    input  logic             issue_hit,
    input  logic             stall_req,
    input  logic [TAG_W-1:0] stall_tag,
    input  logic             retire_req,
    input  logic             cpl_hit,
    input  logic [TAG_W-1:0] cpl_tag,
    output logic             runnable
);

    slot_state_e      state_q, state_d;
    logic [TAG_W-1:0] tag_q, tag_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_DONE;
            tag_q   <= '0;
        end else begin
            state_q <= state_d;
            tag_q   <= tag_d;
        end
    end

    always_comb begin
        state_d = state_q;
        tag_d   = tag_q;
        if (launch) begin
            state_d = enabled ? SLOT_START : SLOT_DONE;
        end else begin
            unique case (state_q)
                SLOT_START, SLOT_READY: begin
                    if (issue_hit) begin
                        if (retire_req) begin
                            state_d = SLOT_DONE;
                        end else if (stall_req) begin
                            state_d = SLOT_STALL;
                            tag_d   = stall_tag;
                        end else begin
                            state_d = SLOT_READY;
                        end
                    end
                end
                SLOT_STALL: begin
                    if (cpl_hit && (cpl_tag == tag_q)) begin
                        state_d = SLOT_READY;
                    end
                end
                SLOT_DONE: begin
                    state_d = SLOT_DONE;
                end
                default: state_d = SLOT_DONE;
            endcase
        end
    end

    always_comb begin
        runnable = (state_q == SLOT_START) || (state_q == SLOT_READY);
    end

endmodule

// File: rtl/grp_rr_pick.sv
module grp_rr_pick #(
    parameter int NUM_SLOTS = 8,
    localparam int GID_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic [NUM_SLOTS-1:0] runnable,
    input  logic [GID_W-1:0]     last_gid,
    output logic                 pick_valid,
    output logic [GID_W-1:0]     pick_gid
);

    always_comb begin
        pick_valid = 1'b0;
        pick_gid   = '0;
        for (int k = 1; k <= NUM_SLOTS; k++) begin
            int cand;
            cand = (int'(last_gid) + k) % NUM_SLOTS;
            if (!pick_valid && runnable[cand]) begin
                pick_valid = 1'b1;
                pick_gid   = GID_W'(cand);
            end
        end
    end

endmodule

// File: rtl/grp_sched.sv
module grp_sched
    import grp_sched_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int TAG_W     = 4,
    localparam int GID_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int CNT_W = $clog2(NUM_SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_slots,
    input  logic             launch,
    input  logic             stall_req,
    input  logic [TAG_W-1:0] stall_tag,
    input  logic             retire_req,
    input  logic             cpl_valid,
    input  logic [GID_W-1:0] cpl_gid,
    input  logic [TAG_W-1:0] cpl_tag,
    output logic             issue_valid,
    output logic [GID_W-1:0] issue_gid
);

    logic [NUM_SLOTS-1:0] runnable;
    logic [GID_W-1:0]     last_q;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        logic enabled_i;
        logic issue_hit_i;
        logic cpl_hit_i;

        assign enabled_i   = (cfg_slots > CNT_W'(i));
        assign issue_hit_i = issue_valid && (issue_gid == GID_W'(i));
        assign cpl_hit_i   = cpl_valid && (cpl_gid == GID_W'(i));

        grp_slot #(.TAG_W(TAG_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .enabled    (enabled_i),
            .launch     (launch),
            .issue_hit  (issue_hit_i),
            .stall_req  (stall_req),
            .stall_tag  (stall_tag),
            .retire_req (retire_req),
            .cpl_hit    (cpl_hit_i),
            .cpl_tag    (cpl_tag),
            .runnable   (runnable[i])
        );
    end

    grp_rr_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
        .runnable   (runnable),
        .last_gid   (last_q),
        .pick_valid (issue_valid),
        .pick_gid   (issue_gid)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= GID_W'(NUM_SLOTS - 1);
        end else if (launch) begin
            last_q <= GID_W'(NUM_SLOTS - 1);
        end else if (issue_valid) begin
            last_q <= issue_gid;
        end
    end

endmodule

// File: rtl/grp_sched_chk.sv
module grp_sched_chk #(
    parameter int NUM_SLOTS = 8,
    localparam int GID_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int CNT_W = $clog2(NUM_SLOTS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cfg_slots,
    input logic             launch,
    input logic             stall_req,
    input logic             retire_req,
    input logic             issue_valid,
    input logic [GID_W-1:0] issue_gid
);

    logic seen_launch;
    int   en_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_launch <= 1'b0;
            en_cnt      <= 0;
        end else if (launch) begin
            seen_launch <= 1'b1;
            en_cnt      <= (int'(cfg_slots) > NUM_SLOTS) ? NUM_SLOTS : int'(cfg_slots);
        end
    end

    // R1: nothing is issued before the first launch
    assert_quiet_before_launch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_launch |-> !issue_valid);

    // R2: only enabled slots are issued
    assert_gid_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (int'(issue_gid) < en_cnt));

    // R4: a group that stalls is not issued in the following cycle
    assert_stall_parks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && stall_req && !launch) |=>
            !(issue_valid && issue_gid == $past(issue_gid)));

    // R8: a group that retires is not issued in the following cycle
    assert_retire_parks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && retire_req && !launch) |=>
            !(issue_valid && issue_gid == $past(issue_gid)));

    // R3: after a launch with slots enabled, slot 0 is issued first
    assert_launch_starts_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && cfg_slots != '0) |=> (issue_valid && issue_gid == '0));

endmodule

bind grp_sched grp_sched_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_slots   (cfg_slots),
    .launch      (launch),
    .stall_req   (stall_req),
    .retire_req  (retire_req),
    .issue_valid (issue_valid),
    .issue_gid   (issue_gid)
);

// File: tb/grp_sched_bench.sv
module grp_sched_bench;

    localparam int N     = 8;
    localparam int TAG_W = 4;
    localparam int GID_W = $clog2(N);
    localparam int CNT_W = $clog2(N + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] cfg_slots = '0;
    logic             launch = 1'b0;
    logic             stall_req = 1'b0;
    logic [TAG_W-1:0] stall_tag = '0;
    logic             retire_req = 1'b0;
    logic             cpl_valid = 1'b0;
    logic [GID_W-1:0] cpl_gid = '0;
    logic [TAG_W-1:0] cpl_tag = '0;
    logic             issue_valid;
    logic [GID_W-1:0] issue_gid;

    always #5 clk = ~clk;

    grp_sched #(.NUM_SLOTS(N), .TAG_W(TAG_W)) u_grp_sched (
        .clk(clk), .rst_n(rst_n), .cfg_slots(cfg_slots), .launch(launch),
        .stall_req(stall_req), .stall_tag(stall_tag), .retire_req(retire_req),
        .cpl_valid(cpl_valid), .cpl_gid(cpl_gid), .cpl_tag(cpl_tag),
        .issue_valid(issue_valid), .issue_gid(issue_gid)
    );

    // reference model: 0 start, 1 ready, 2 stalled, 3 done
    int m_st[N];
    int m_tag[N];
    int m_last;
    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // auto-traffic state: per-group memory latency countdowns
    bit auto_on = 0;
    int lat_cnt[N];
    int iss_cnt[N];
    int auto_tag = 0;

    task automatic pick(output bit v, output int g);
        v = 0; g = 0;
        for (int k = 1; k <= N; k++) begin
            int c;
            c = (m_last + k) % N;
            if (!v && m_st[c] < 2) begin v = 1; g = c; end
        end
    endtask

    task automatic check(input string lbl, input bit ev, input int eg);
        checks++;
        if (issue_valid !== ev || (ev && int'(issue_gid) != eg)) begin
            failures++;
            $display("FAIL %s: issue_valid=%0b issue_gid=%0d expected valid=%0b gid=%0d",
                     lbl, issue_valid, issue_gid, ev, eg);
        end
    endtask

    task automatic auto_stim(input bit ev, input int eg);
        int served;
        served = -1;
        for (int g = 0; g < N; g++)
            if (lat_cnt[g] > 0) lat_cnt[g]--;
        for (int g = 0; g < N; g++)
            if (served < 0 && lat_cnt[g] == 0) served = g;
        if (served >= 0) begin
            cpl_valid = 1; cpl_gid = GID_W'(served); cpl_tag = TAG_W'(m_tag[served]);
            lat_cnt[served] = -1;
        end
        if (ev) begin
            // R4: an issued group must not be waiting on memory
            checks++;
            if (lat_cnt[eg] != -1 && served != eg) begin
                failures++;
                $display("FAIL R4 resume order: gid=%0d issued with latency left %0d expected -1",
                         eg, lat_cnt[eg]);
            end
            iss_cnt[eg]++;
            if (iss_cnt[eg] >= 6) begin
                retire_req = 1;
            end else begin
                stall_req = 1;
                auto_tag  = (auto_tag + 1) % (1 << TAG_W);
                stall_tag = TAG_W'(auto_tag);
                lat_cnt[eg] = 20 + 13 * eg;
            end
        end
    endtask

    task automatic model_update(input bit ev, input int eg);
        if (launch) begin
            for (int g = 0; g < N; g++) m_st[g] = (g < int'(cfg_slots)) ? 0 : 3;
            m_last = N - 1;
        end else begin
            if (cpl_valid && m_st[cpl_gid] == 2 && m_tag[cpl_gid] == int'(cpl_tag))
                m_st[cpl_gid] = 1;
            if (ev) begin
                if (retire_req) m_st[eg] = 3;
                else if (stall_req) begin m_st[eg] = 2; m_tag[eg] = int'(stall_tag); end
                else m_st[eg] = 1;
                m_last = eg;
            end
        end
    endtask

    task automatic tick(input string lbl);
        bit ev; int eg;
        @(negedge clk);
        pick(ev, eg);
        check(lbl, ev, eg);
        if (auto_on) auto_stim(ev, eg);
        model_update(ev, eg);
        @(posedge clk);
        #1;
        launch = 0; stall_req = 0; retire_req = 0; cpl_valid = 0;
    endtask

    task automatic ticks(input string lbl, input int n);
        for (int i = 0; i < n; i++) tick(lbl);
    endtask

    task automatic complete(input int g, input int t);
        cpl_valid = 1; cpl_gid = GID_W'(g); cpl_tag = TAG_W'(t);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog: run did not end, expected completion");
        summary();
    end

    initial begin
        for (int g = 0; g < N; g++) begin m_st[g] = 3; m_tag[g] = 0; lat_cnt[g] = -1; iss_cnt[g] = 0; end
        m_last = N - 1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1: idle after reset, stray inputs do not start anything
        ticks("R1 reset idle", 3);
        stall_req = 1; complete(0, 0); tick("R1 stray inputs");
        ticks("R1 still idle", 2);

        // R2 / R3: three slots, round-robin from slot 0
        cfg_slots = 3; launch = 1; tick("R2 launch cycle");
        ticks("R3 rotation over three slots", 7);

        // R4: stall the next issued group (slot 1 after 0,1,2,0,1,2,0)
        stall_req = 1; stall_tag = 5; tick("R4 stall issue");
        ticks("R4 stalled slot skipped", 4);
        // R6: wrong tag, and completion for a non-stalled group
        complete(1, 4); tick("R6 tag mismatch ignored");
        ticks("R6 still parked", 3);
        complete(0, 5); tick("R6 completion for ready group ignored");
        ticks("R6 ready group unaffected", 2);
        // R5: matching completion wakes the group
        complete(1, 5); tick("R5 matching completion");
        ticks("R5 woken slot back in rotation", 4);

        // R7: stall all three groups
        stall_req = 1; stall_tag = 1; tick("R7 stall a");
        stall_req = 1; stall_tag = 2; tick("R7 stall b");
        stall_req = 1; stall_tag = 3; tick("R7 stall c");
        ticks("R7 nothing runnable", 3);
        for (int g = 0; g < 3; g++) begin complete(g, (m_tag[g])); tick("R5 wake one of three"); end
        ticks("R5 rotation resumed", 4);

        // R9 / R8: retire with stall on the next issued group, then try to wake it
        retire_req = 1; stall_req = 1; stall_tag = 9; tick("R9 retire beats stall");
        for (int g = 0; g < 3; g++) begin complete(g, 9); tick("R9 completion cannot revive"); end
        ticks("R8 retired group never issued", 6);

        // R10: launch mid-run with all slots, overriding stall in same cycle
        cfg_slots = 8; launch = 1; stall_req = 1; retire_req = 1; tick("R10 launch overrides");
        ticks("R10 restart from slot 0", 10);

        // R2: clamp of oversized count
        cfg_slots = 12; launch = 1; tick("R2 oversized count");
        ticks("R2 clamped to all slots", 9);

        // R4 / R5: latency-driven traffic over all slots until every group retires
        cfg_slots = 8; launch = 1; tick("R10 relaunch for traffic");
        auto_on = 1;
        ticks("R5 latency traffic", 1500);
        auto_on = 0;
        ticks("R8 all retired idle", 4);

        // R2: zero slots enables nothing
        cfg_slots = 0; launch = 1; tick("R2 zero slots launch");
        ticks("R2 zero slots idle", 4);

        summary();
    end

endmodule